// File: doc/BRIEF.md
# Lockstep Diagnostic Error Monitor

This block sits beside a functional datapath that runs in lockstep with a diagnostic copy of itself. Every clock it compares the two copies and keeps two sticky error flags for the display logic. The first flag watches a 15-line gated-clock bus. The functional and diagnostic generators must drive identical values on it, and the comparison is split into four comparator groups. The second flag watches the top data bit from each multiplexer copy. The diagnostic multiplexer produces the inverse of the functional one, so the two bits must always differ.

A self-test input forces both flags on, so the operator can see that the indicators work. An error-reset input clears them. Upstream logic asserts error-reset when self-test is switched off or when a display-reset control is pressed. For debug, the block also exports a combinational vector with one mismatch bit per comparator group.

Top module: `lem_err_mon`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released with no set condition, `gclk_err_o` and `data_err_o` are 0.
- R2: If any bit of `fn_gclk_i` differs from the same bit of `dg_gclk_i` at a rising clock edge, `gclk_err_o` is 1 after that edge.
- R3: `grp_miss_o[g]` is combinational. It is 1 exactly when any bit of group g differs between the two buses. Group 0 covers bits 0 to 3, group 1 covers bits 4 to 7, group 2 covers bits 8 to 11 and group 3 covers bits 12 to 14.
- R4: At a rising edge, `fn_msb_i` differing from `dg_msb_i` is the no-error case and sets nothing. If the two bits are equal, `data_err_o` is 1 after that edge.
- R5: Once set, each flag stays at 1 until an edge where `err_clr_i` is 1, even after its mismatch has gone away.
- R6: At an edge with `err_clr_i` = 1, a flag whose own set condition is absent becomes 0.
- R7: At an edge with `self_test_i` = 1, both flags are 1 after that edge, whatever the data inputs are.
- R8: If a flag's set condition and `err_clr_i` are present at the same edge, that flag is 1 after the edge.
- R9: The flags are independent. A gated-clock mismatch alone never sets `data_err_o`, and a data error alone never sets `gclk_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fn_gclk_i | input | 15 | Gated-clock bus from the functional generator |
| dg_gclk_i | input | 15 | Gated-clock bus from the diagnostic generator |
| fn_msb_i | input | 1 | Top data bit from the functional multiplexer |
| dg_msb_i | input | 1 | Top data bit from the diagnostic multiplexer (expected inverted) |
| self_test_i | input | 1 | Forces both error flags on |
| err_clr_i | input | 1 | Clears both error flags |
| gclk_err_o | output | 1 | Sticky gated-clock mismatch flag |
| data_err_o | output | 1 | Sticky data-complement error flag |
| grp_miss_o | output | 4 | Per-group gated-clock mismatch, combinational |

## Verification
The comparator groups are exercised in three ways:
- Single-bit faults walked across all 15 lines check that each line lands in the right group and that the last group is three bits wide.
- Random multi-bit faults catch grouping or OR-reduction errors.
- Equal buses confirm that no group reports a false mismatch.

The data check is driven with complementary bit pairs and with both equal pairs (00 and 11). This separates an XOR-based check from an equality check with the wrong sense.

Directed sequences then cover:
- a mismatch that disappears while the flag must stay set;
- error-reset on the same edge as a mismatch, and error-reset on the same edge as self-test;
- a fault in one check while the other check's inputs stay clean, which proves the two flags are separate.

// File: rtl/lem_pkg.sv
package lem_pkg;

  // Number of comparator groups needed to cover a bus of width w in spans of s.
  function automatic int num_groups(input int w, input int s);
    return (w + s - 1) / s;
  endfunction

  // Lowest bit index of group g.
  function automatic int grp_lo(input int g, input int s);
    return g * s;
  endfunction

  // Width of group g; the last group may be narrower than the span.
  function automatic int grp_width(input int g, input int w, input int s);
    int rem;
    rem = w - g * s;
    return (rem < s) ? rem : s;
  endfunction

endpackage

// File: rtl/lem_grp_cmp.sv
module lem_grp_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] fn_i,
  input  logic [W-1:0] dg_i,
  output logic         miss_o
);

  logic [W-1:0] diff;

  always_comb begin
    diff   = fn_i ^ dg_i;
    miss_o = |diff;
  end

endmodule

// File: rtl/lem_cpl_chk.sv
module lem_cpl_chk (
  input  logic fn_i,
  input  logic dg_i,
  output logic err_o
);

  logic differ;

  // The copies are expected to be inverted: a difference is healthy.
  always_comb begin
    differ = fn_i ^ dg_i;
    err_o  = ~differ;
  end

endmodule

// File: rtl/lem_sticky_flag.sv
module lem_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Next state: set has priority over clear.
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R5: a set flag holds while no clear arrives
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  // R8: a set request wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

endmodule

// File: rtl/lem_err_mon.sv
module lem_err_mon #(
  parameter int GCLK_W   = 15,
  parameter int GRP_SPAN = 4,
  localparam int NUM_GRP = lem_pkg::num_groups(GCLK_W, GRP_SPAN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GCLK_W-1:0]  fn_gclk_i,
  input  logic [GCLK_W-1:0]  dg_gclk_i,
  input  logic               fn_msb_i,
  input  logic               dg_msb_i,
  input  logic               self_test_i,
  input  logic               err_clr_i,
  output logic               gclk_err_o,
  output logic               data_err_o,
  output logic [NUM_GRP-1:0] grp_miss_o
);

  logic [NUM_GRP-1:0] grp_miss;
  logic               gclk_miss;
  logic               data_bad;
  logic               gclk_set;
  logic               data_set;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = lem_pkg::grp_lo(g, GRP_SPAN);
    localparam int GW = lem_pkg::grp_width(g, GCLK_W, GRP_SPAN);

    lem_grp_cmp #(.W(GW)) u_cmp (
      .fn_i   (fn_gclk_i[LO +: GW]),
      .dg_i   (dg_gclk_i[LO +: GW]),
      .miss_o (grp_miss[g])
    );
  end

  lem_cpl_chk u_cpl (
    .fn_i  (fn_msb_i),
    .dg_i  (dg_msb_i),
    .err_o (data_bad)
  );

  always_comb begin
    gclk_miss = |grp_miss;
    gclk_set  = gclk_miss | self_test_i;
    data_set  = data_bad  | self_test_i;
  end

  lem_sticky_flag u_gclk_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (gclk_set),
    .clr_i  (err_clr_i),
    .flag_o (gclk_err_o)
  );

  lem_sticky_flag u_data_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (data_set),
    .clr_i  (err_clr_i),
    .flag_o (data_err_o)
  );

  assign grp_miss_o = grp_miss;

  // R2: any bus bit difference is flagged after the edge
  p_gclk_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_gclk_i != dg_gclk_i) |=> gclk_err_o);

  // R4: equal top bits are flagged after the edge
  p_data_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_msb_i == dg_msb_i) |=> data_err_o);

  // R6: clear without a set condition drops the gated-clock flag
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !self_test_i && (fn_gclk_i == dg_gclk_i)) |=> !gclk_err_o);

  // R7: self-test forces both flags
  p_selftest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_test_i |=> (gclk_err_o && data_err_o));

  // R9: the data flag only rises from its own cause
  p_data_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_err_o) |-> $past((fn_msb_i == dg_msb_i) || self_test_i));

endmodule

// File: tb/lem_err_mon_tb.sv
module lem_err_mon_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 15;
  localparam int NG = 4;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  fn_gclk, dg_gclk;
  logic          fn_msb, dg_msb, self_test, err_clr;
  logic          gclk_err, data_err;
  logic [NG-1:0] grp_miss;

  int  checks = 0;
  int  failures = 0;
  logic exp_g, exp_d;

  lem_err_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fn_gclk_i(fn_gclk), .dg_gclk_i(dg_gclk),
    .fn_msb_i(fn_msb), .dg_msb_i(dg_msb),
    .self_test_i(self_test), .err_clr_i(err_clr),
    .gclk_err_o(gclk_err), .data_err_o(data_err),
    .grp_miss_o(grp_miss)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NG-1:0] exp_groups(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [NG-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) if (a[i] != b[i]) r[i/4] = 1'b1;
    return r;
  endfunction

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, check groups, then flags just after the rising edge.
  task automatic step(input logic [W-1:0] fg, input logic [W-1:0] dg,
                      input logic fm, input logic dm, input logic st, input logic clr,
                      input string tag_g, input string tag_d);
    fn_gclk = fg; dg_gclk = dg; fn_msb = fm; dg_msb = dm; self_test = st; err_clr = clr;
    #1;
    check("R3 grp_miss", 32'(grp_miss), 32'(exp_groups(fg, dg)));
    @(posedge clk);
    #1;
    exp_g = next_flag(exp_g, (fg != dg) | st, clr);
    exp_d = next_flag(exp_d, (fm == dm) | st, clr);
    check(tag_g, 32'(gclk_err), 32'(exp_g));
    check(tag_d, 32'(data_err), 32'(exp_d));
    @(negedge clk);
  endtask

  task automatic quiet(input logic clr, input string tg, input string td);
    step('0, '0, 1'b0, 1'b1, 1'b0, clr, tg, td);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    logic m;
    void'($urandom(32'd4242));
    rst_n = 1'b0; fn_gclk = '0; dg_gclk = '0; fn_msb = 1'b0; dg_msb = 1'b1;
    self_test = 1'b0; err_clr = 1'b0;
    exp_g = 1'b0; exp_d = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 gclk in reset", 32'(gclk_err), 32'd0);
    check("R1 data in reset", 32'(data_err), 32'd0);
    rst_n = 1'b1;
    quiet(1'b0, "R1 gclk after reset", "R1 data after reset");

    // R2/R3: walk a single fault across every line.
    for (int i = 0; i < W; i++) begin
      step(15'(1 << i), '0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 single-bit fault", "R6 data cleared");
      quiet(1'b1, "R6 gclk cleared", "R6 data cleared");
    end

    // R4: both equal pairs, then a complementary pair.
    step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 gclk untouched by data", "R4 equal 00");
    quiet(1'b1, "R6 gclk", "R6 data clear");
    step('0, '0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 gclk untouched by data", "R4 equal 11");
    quiet(1'b1, "R6 gclk", "R6 data clear");
    step('0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 gclk", "R4 complement ok");

    // R5: fault then go quiet without clear.
    step(15'h4000, 15'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R2 top group", "R4 equal");
    quiet(1'b0, "R5 gclk sticky", "R5 data sticky");
    quiet(1'b0, "R5 gclk sticky", "R5 data sticky");
    // R8: gated-clock fault together with clear; data check healthy.
    step(15'h0010, 15'h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R8 set wins over clear", "R6 data cleared");
    quiet(1'b1, "R6 gclk cleared", "R6 data");
    // R9: gated-clock fault only.
    step(15'h0100, 15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R2 gclk", "R9 data stays 0");
    quiet(1'b1, "R6 gclk", "R6 data");
    // R7: self-test with clean inputs, then with clear.
    step('0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 self-test gclk", "R7 self-test data");
    step('0, '0, 1'b0, 1'b1, 1'b1, 1'b1, "R8 self-test over clear gclk", "R8 self-test over clear data");
    quiet(1'b1, "R6 gclk after self-test", "R6 data after self-test");

    // Random mix.
    for (int n = 0; n < 400; n++) begin
      a = 15'($urandom);
      b = ($urandom_range(0, 3) == 0) ? (a ^ 15'($urandom)) : a;
      m = 1'($urandom);
      step(a, b, m, ($urandom_range(0, 4) == 0) ? m : ~m,
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0),
           "R2 R5 R8 random gclk", "R4 R5 R8 random data");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule